// File: doc/BRIEF.md
# Rate Sensor SPI Message Responder

This block is the sensor-side end of a full-duplex SPI link. A host drives the select, serial clock and data-in lines and receives one 48-bit frame per selection. In the same frame it sends six bytes of its own: a control byte, four zero bytes and a checksum. The block checks each incoming request and builds every outgoing frame. An outgoing frame holds a status byte, four payload bytes and a checksum. The payload content depends on the message type that the host asked for in the previous frame.

The measured quantities arrive as parallel input words: signed rate, two auxiliary channels, temperature and two 16-bit configuration records. The same applies to the rate check byte and to the self-test status bits. The serial lines are synchronised into the system clock domain, and the serial clock is oversampled. The outgoing frame is captured as a snapshot at the moment the select line falls. A rolling message count and a host-fault flag in the status byte let the host track lost or rejected frames.

Top module: `rate_msg_responder`

## Requirements
- R1: While the select line is high, the data-out enable is 0, and activity on the serial clock and data-in lines changes neither the message count nor the content of the next frame.
- R2: A transfer is 48 serial clocks in SPI mode 0, most significant bit first. Data-out is enabled for the whole selection, and its first bit is valid before the first rising edge.
- R3: Outgoing byte 5 is the bitwise inverse of the 8-bit sum of outgoing bytes 0 to 4. A host request is valid only if its byte 5 equals the inverse of the 8-bit sum of its bytes 0 to 4.
- R4: The outgoing status byte (byte 0) is laid out as follows: bits 7:6 message count, bit 5 host fault, bit 4 self-test fault input, bit 3 self-test active input, bits 2:0 type of the current message.
- R5: After reset, and until a valid request arrives, the message type sent is 4 (configuration record 1).
- R6: A valid request selects, through control bits 2:0, the type of the next frame. Outgoing bytes 3 and 4 then carry the following, MS byte first: type 1 auxiliary word 1, type 2 auxiliary word 2, type 3 temperature, type 4 configuration record 1, type 5 configuration record 2.
- R7: A request with a wrong checksum, a nonzero bit in control bits 7:4, or type code 6 or 7 is rejected. A rejected request leaves the last valid type in force and sets the host-fault bit in the next status byte. A valid request clears the host-fault bit.
- R8: A selection that ends after fewer than 48 serial clocks is rejected as in R7 and does not advance the message count.
- R9: The 2-bit message count advances by one, modulo 4, at the end of every 48-clock frame, whether the request in it was valid or not. It starts at 0 after reset.
- R10: The self-test request output equals bit 3 of the last valid control byte. It is 0 after reset.
- R11: All outgoing bytes are taken from the inputs at the fall of select. Input changes during the frame do not appear in that frame.
- R12: In every type, bytes 1 and 2 carry the signed rate word, MS byte first. Type 0 puts the rate check byte in byte 3 and zero in byte 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Select, active low, frames a transfer |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Drive enable for spi_miso (high-impedance when 0) |
| rate_word | input | 16 | Signed rate sample |
| rate_chk | input | 8 | Rate check byte |
| aux1_word | input | 16 | Auxiliary channel 1 sample |
| aux2_word | input | 16 | Auxiliary channel 2 sample |
| temp_word | input | 16 | Temperature sample |
| cfg1_word | input | 16 | Configuration record 1 |
| cfg2_word | input | 16 | Configuration record 2 |
| st_fault | input | 1 | Self-test fault status |
| st_active | input | 1 | Self-test active status |
| selftest_req | output | 1 | Commanded self-test request |

## Verification
Two things can fall in nearly the same cycle: the end-of-frame commit and the snapshot of the next frame. The commit updates the type, the count and the fault flag. The snapshot is taken at the next fall of select. The bench provokes this with back-to-back frames separated by only two system clocks of select high. It judges the result by whether the second frame already carries the type, count and fault that the first request produced. A second overlap is also exercised: payload inputs change in the middle of a frame, and the received frame must still hold the values that were present at the fall of select.

// File: rtl/rate_msg_pkg.sv
package rate_msg_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 6;
    localparam int FRAME_W     = BYTE_W * FRAME_BYTES;
    localparam int WORD_W      = 16;
    localparam int BITCNT_W    = $clog2(FRAME_W + 1);
    localparam int MCNT_W      = 2;

    typedef enum logic [2:0] {
        MT_RATE = 3'd0,
        MT_AUX1 = 3'd1,
        MT_AUX2 = 3'd2,
        MT_TEMP = 3'd3,
        MT_CFG1 = 3'd4,
        MT_CFG2 = 3'd5
    } msg_type_e;

    localparam logic [2:0] MT_LIMIT = 3'd6;
endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sclk_in,
    input  logic mosi_in,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] cs_d, cs_q;
    logic [DEPTH-1:0] ck_d, ck_q;
    logic [DEPTH-1:0] dt_d, dt_q;

    always_comb begin
        cs_d = {cs_q[DEPTH-2:0], cs_n_in};
        ck_d = {ck_q[DEPTH-2:0], sclk_in};
        dt_d = {dt_q[DEPTH-2:0], mosi_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '1;
            ck_q <= '0;
            dt_q <= '0;
        end else begin
            cs_q <= cs_d;
            ck_q <= ck_d;
            dt_q <= dt_d;
        end
    end

    assign cs_fall   =  cs_q[DEPTH-1] & ~cs_q[DEPTH-2];
    assign cs_rise   = ~cs_q[DEPTH-1] &  cs_q[DEPTH-2];
    assign sclk_rise = ~ck_q[DEPTH-1] &  ck_q[DEPTH-2];
    assign sclk_fall =  ck_q[DEPTH-1] & ~ck_q[DEPTH-2];
    assign mosi_s    =  dt_q[DEPTH-2];
endmodule

// File: rtl/host_req_check.sv
module host_req_check
    import rate_msg_pkg::*;
(
    input  logic [FRAME_W-1:0]  rx_frame,
    input  logic [BITCNT_W-1:0] bits_seen,
    output logic                req_ok,
    output logic                frame_full,
    output logic [2:0]          req_type,
    output logic                req_selftest
);
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] sum;
    logic [BYTE_W-1:0] chk;
    logic              sum_ok;
    logic              ctrl_ok;

    always_comb begin
        ctrl = rx_frame[FRAME_W-1 -: BYTE_W];
        chk  = rx_frame[BYTE_W-1:0];
        sum  = '0;
        for (int i = 1; i < FRAME_BYTES; i++) begin
            sum = sum + rx_frame[i*BYTE_W +: BYTE_W];
        end
        sum_ok       = (chk == ~sum);
        ctrl_ok      = (ctrl[7:4] == 4'h0) && (ctrl[2:0] < MT_LIMIT);
        frame_full   = (bits_seen == BITCNT_W'(FRAME_W));
        req_ok       = frame_full && sum_ok && ctrl_ok;
        req_type     = ctrl[2:0];
        req_selftest = ctrl[3];
    end
endmodule

// File: rtl/reply_frame_build.sv
module reply_frame_build
    import rate_msg_pkg::*;
(
    input  logic [2:0]         cur_type,
    input  logic [MCNT_W-1:0]  msg_cnt,
    input  logic               host_fault,
    input  logic               st_fault,
    input  logic               st_active,
    input  logic [WORD_W-1:0]  rate_word,
    input  logic [BYTE_W-1:0]  rate_chk,
    input  logic [WORD_W-1:0]  aux1_word,
    input  logic [WORD_W-1:0]  aux2_word,
    input  logic [WORD_W-1:0]  temp_word,
    input  logic [WORD_W-1:0]  cfg1_word,
    input  logic [WORD_W-1:0]  cfg2_word,
    output logic [FRAME_W-1:0] frame
);
    logic [BYTE_W-1:0] bytes [FRAME_BYTES];
    logic [WORD_W-1:0] tail;
    logic [BYTE_W-1:0] sum;

    always_comb begin
        case (cur_type)
            MT_AUX1: tail = aux1_word;
            MT_AUX2: tail = aux2_word;
            MT_TEMP: tail = temp_word;
            MT_CFG1: tail = cfg1_word;
            MT_CFG2: tail = cfg2_word;
            default: tail = {rate_chk, 8'h00};
        endcase
        bytes[0] = {msg_cnt, host_fault, st_fault, st_active, cur_type};
        bytes[1] = rate_word[15:8];
        bytes[2] = rate_word[7:0];
        bytes[3] = tail[15:8];
        bytes[4] = tail[7:0];
        sum = '0;
        for (int i = 0; i < FRAME_BYTES - 1; i++) begin
            sum = sum + bytes[i];
        end
        bytes[FRAME_BYTES-1] = ~sum;
        for (int i = 0; i < FRAME_BYTES; i++) begin
            frame[FRAME_W-1-i*BYTE_W -: BYTE_W] = bytes[i];
        end
    end
endmodule

// File: rtl/rate_msg_responder.sv
module rate_msg_responder
    import rate_msg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_sclk,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_miso_en,
    input  logic [15:0] rate_word,
    input  logic [7:0]  rate_chk,
    input  logic [15:0] aux1_word,
    input  logic [15:0] aux2_word,
    input  logic [15:0] temp_word,
    input  logic [15:0] cfg1_word,
    input  logic [15:0] cfg2_word,
    input  logic        st_fault,
    input  logic        st_active,
    output logic        selftest_req
);
    typedef struct packed {
        logic [FRAME_W-1:0]  tx;
        logic [FRAME_W-1:0]  rx;
        logic [BITCNT_W-1:0] nbits;
        logic                active;
        logic [MCNT_W-1:0]   msg_cnt;
        logic                host_fault;
        logic [2:0]          next_type;
        logic                st_req;
    } resp_state_t;

    resp_state_t state_d, state_q;

    logic cs_fall, cs_rise, sclk_rise, sclk_fall, mosi_s;
    logic req_ok, frame_full, req_selftest;
    logic [2:0] req_type;
    logic [FRAME_W-1:0] reply;

    spi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_in   (spi_cs_n),
        .sclk_in   (spi_sclk),
        .mosi_in   (spi_mosi),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s)
    );

    host_req_check u_check (
        .rx_frame     (state_q.rx),
        .bits_seen    (state_q.nbits),
        .req_ok       (req_ok),
        .frame_full   (frame_full),
        .req_type     (req_type),
        .req_selftest (req_selftest)
    );

    reply_frame_build u_build (
        .cur_type   (state_q.next_type),
        .msg_cnt    (state_q.msg_cnt),
        .host_fault (state_q.host_fault),
        .st_fault   (st_fault),
        .st_active  (st_active),
        .rate_word  (rate_word),
        .rate_chk   (rate_chk),
        .aux1_word  (aux1_word),
        .aux2_word  (aux2_word),
        .temp_word  (temp_word),
        .cfg1_word  (cfg1_word),
        .cfg2_word  (cfg2_word),
        .frame      (reply)
    );

    always_comb begin
        state_d = state_q;
        if (cs_fall) begin
            state_d.active = 1'b1;
            state_d.tx     = reply;
            state_d.rx     = '0;
            state_d.nbits  = '0;
        end else if (state_q.active) begin
            if (sclk_rise) begin
                state_d.rx = {state_q.rx[FRAME_W-2:0], mosi_s};
                if (state_q.nbits != '1) begin
                    state_d.nbits = state_q.nbits + 1'b1;
                end
            end
            if (sclk_fall) begin
                state_d.tx = {state_q.tx[FRAME_W-2:0], 1'b0};
            end
            if (cs_rise) begin
                state_d.active     = 1'b0;
                state_d.host_fault = ~req_ok;
                if (frame_full) begin
                    state_d.msg_cnt = state_q.msg_cnt + 1'b1;
                end
                if (req_ok) begin
                    state_d.next_type = req_type;
                    state_d.st_req    = req_selftest;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q           <= '0;
            state_q.next_type <= MT_CFG1;
        end else begin
            state_q <= state_d;
        end
    end

    assign spi_miso     = state_q.active & state_q.tx[FRAME_W-1];
    assign spi_miso_en  = state_q.active;
    assign selftest_req = state_q.st_req;
endmodule

// File: rtl/rate_msg_checker.sv
module rate_msg_checker
    import rate_msg_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cs_fall,
    input logic                cs_rise,
    input logic                active,
    input logic [FRAME_W-1:0]  tx,
    input logic [FRAME_W-1:0]  rx,
    input logic [BITCNT_W-1:0] nbits,
    input logic [MCNT_W-1:0]   msg_cnt,
    input logic                host_fault,
    input logic                spi_miso_en
);
    p_idle_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cs_fall) |=> ($stable(rx) && $stable(nbits) && $stable(tx)));

    p_miso_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cs_fall) |=> !spi_miso_en);

    p_type_loaded_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (tx[42:40] < MT_LIMIT));

    p_fault_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(host_fault));

    p_short_no_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && active && nbits != BITCNT_W'(FRAME_W)) |=> $stable(msg_cnt));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_cnt != $past(msg_cnt)) |-> (msg_cnt == $past(msg_cnt) + 2'd1));
endmodule

bind rate_msg_responder rate_msg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .active      (state_q.active),
    .tx          (state_q.tx),
    .rx          (state_q.rx),
    .nbits       (state_q.nbits),
    .msg_cnt     (state_q.msg_cnt),
    .host_fault  (state_q.host_fault),
    .spi_miso_en (spi_miso_en)
);

// File: tb/sim_rate_msg_responder.sv
`timescale 1ns/1ps
module sim_rate_msg_responder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_en, st_req;
    logic [15:0] rate_w = 16'hF3A5, aux1_w = 16'h0ABC, aux2_w = 16'h0123;
    logic [15:0] temp_w = 16'h1F40, cfg1_w = 16'hC0DE, cfg2_w = 16'h5A17;
    logic [7:0]  rchk = 8'h6B;
    logic        stf = 1'b0, sta = 1'b0;

    int checks = 0, errors = 0;
    logic [2:0] m_type = 3'd4;
    logic [1:0] m_cnt = 2'd0;
    logic       m_fault = 1'b0, m_st = 1'b0;
    logic [47:0] rx_last;

    always #5 clk = ~clk;

    rate_msg_responder u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en), .rate_word(rate_w), .rate_chk(rchk),
        .aux1_word(aux1_w), .aux2_word(aux2_w), .temp_word(temp_w), .cfg1_word(cfg1_w),
        .cfg2_word(cfg2_w), .st_fault(stf), .st_active(sta), .selftest_req(st_req)
    );

    task automatic check(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] req_frame(input logic [7:0] ctrl);
        return {ctrl, 32'h0, ~ctrl};
    endfunction

    function automatic logic [47:0] model_frame(input logic [2:0] t, input logic [1:0] c, input logic f);
        logic [7:0] b [6];
        logic [15:0] tl;
        logic [7:0] s;
        case (t)
            3'd1: tl = aux1_w;
            3'd2: tl = aux2_w;
            3'd3: tl = temp_w;
            3'd4: tl = cfg1_w;
            3'd5: tl = cfg2_w;
            default: tl = {rchk, 8'h00};
        endcase
        b[0] = {c, f, stf, sta, t};
        b[1] = rate_w[15:8]; b[2] = rate_w[7:0]; b[3] = tl[15:8]; b[4] = tl[7:0];
        s = b[0] + b[1] + b[2] + b[3] + b[4];
        b[5] = ~s;
        return {b[0], b[1], b[2], b[3], b[4], b[5]};
    endfunction

    // One selection: nbits clocks, optional mid-frame rate change, gap after
    task automatic xfer(input logic [47:0] tx, input int nbits, input string req,
                        input logic mutate, input int gap);
        logic [47:0] exp, got;
        logic en_ok;
        logic [7:0] c;
        logic ok;
        exp = model_frame(m_type, m_cnt, m_fault);
        got = '0;
        en_ok = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[47-i];
            repeat (8) @(negedge clk);
            got = {got[46:0], miso};
            en_ok = en_ok & miso_en;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            if (mutate && i == 8) rate_w = ~rate_w;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        if (nbits == 48) begin
            check(got == exp, req, got, exp);
            check(en_ok, "R2 miso enabled", {47'd0, en_ok}, 48'd1);
        end
        rx_last = got;
        c = tx[47:40];
        ok = (nbits == 48) && (tx[7:0] == ~(tx[47:40] + tx[39:32] + tx[31:24] + tx[23:16] + tx[15:8]))
             && (c[7:4] == 4'h0) && (c[2:0] < 3'd6);
        if (nbits == 48) m_cnt = m_cnt + 2'd1;
        m_fault = !ok;
        if (ok) begin m_type = c[2:0]; m_st = c[3]; end
        if (mutate) rate_w = ~rate_w;
        repeat (gap) @(negedge clk);
    endtask

    task automatic t_reset();
        check(miso_en == 1'b0, "R1 reset miso_en", {47'd0, miso_en}, 48'd0);
        check(st_req == 1'b0, "R10 reset selftest", {47'd0, st_req}, 48'd0);
        // R5: first frame after reset is configuration 1
        xfer(req_frame(8'h00), 48, "R5 first frame cfg1", 1'b0, 12);
    endtask

    task automatic t_types();
        // R6 R12 R9 R3 R4: walk every type; count wraps past 3
        xfer(req_frame(8'h01), 48, "R12 basic rate frame", 1'b0, 12);
        xfer(req_frame(8'h02), 48, "R6 aux1 frame", 1'b0, 12);
        xfer(req_frame(8'h03), 48, "R6 aux2 frame", 1'b0, 12);
        xfer(req_frame(8'h05), 48, "R6 temp frame", 1'b0, 12);
        xfer(req_frame(8'h04), 48, "R6 cfg2 frame", 1'b0, 12);
        xfer(req_frame(8'h00), 48, "R9 cfg1 frame count wrap", 1'b0, 12);
        check(rx_last[47:46] == 2'd2, "R9 count field", {46'd0, rx_last[47:46]}, 48'd2);
    endtask

    task automatic t_invalid();
        xfer({8'h01, 32'h0, 8'h00}, 48, "R7 before bad checksum", 1'b0, 12);
        xfer(req_frame(8'h12), 48, "R7 after bad checksum keeps type", 1'b0, 12);
        check(rx_last[45] == 1'b1, "R7 fault flag set", {47'd0, rx_last[45]}, 48'd1);
        xfer(req_frame(8'h07), 48, "R7 after reserved bit", 1'b0, 12);
        xfer(req_frame(8'h03), 48, "R7 after reserved type", 1'b0, 12);
        xfer(req_frame(8'h00), 48, "R7 valid clears fault", 1'b0, 12);
        check(rx_last[45] == 1'b0 && rx_last[42:40] == 3'd3, "R7 fault cleared",
              {40'd0, rx_last[47:40]}, {40'd0, 8'h03});
    endtask

    task automatic t_short();
        logic [1:0] c0;
        c0 = m_cnt;
        xfer(req_frame(8'h02), 20, "R8 short", 1'b0, 12);
        xfer(req_frame(8'h00), 48, "R8 after short frame", 1'b0, 12);
        check(rx_last[47:46] == c0 && rx_last[45], "R8 count held and fault",
              {45'd0, rx_last[47:45]}, {45'd0, c0, 1'b1});
    endtask

    task automatic t_selftest();
        xfer(req_frame(8'h08), 48, "R10 request selftest", 1'b0, 12);
        check(st_req == 1'b1, "R10 selftest set", {47'd0, st_req}, 48'd1);
        stf = 1'b1; sta = 1'b1;
        xfer(req_frame(8'h1C), 48, "R4 status bits from inputs", 1'b0, 12);
        check(st_req == 1'b1, "R10 invalid keeps request", {47'd0, st_req}, 48'd1);
        stf = 1'b0; sta = 1'b0;
        xfer(req_frame(8'h00), 48, "R4 status after clear", 1'b0, 12);
        check(st_req == 1'b0, "R10 selftest cleared", {47'd0, st_req}, 48'd0);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            sclk = i[0];
            mosi = i[1];
            check(miso_en == 1'b0, "R1 idle miso_en", {47'd0, miso_en}, 48'd0);
        end
        sclk = 1'b0;
        repeat (10) @(negedge clk);
        xfer(req_frame(8'h01), 48, "R1 frame after idle noise", 1'b0, 12);
    endtask

    task automatic t_midframe();
        xfer(req_frame(8'h01), 48, "R11 rate change mid-frame", 1'b1, 12);
        // back-to-back: select high only two system clocks
        xfer(req_frame(8'h05), 48, "R6 back-to-back first", 1'b0, 2);
        xfer(req_frame(8'h00), 48, "R6 back-to-back second", 1'b0, 12);
        check(rx_last[42:40] == 3'd5, "R6 back-to-back type", {45'd0, rx_last[42:40]}, 48'd5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_types();
        t_invalid();
        t_short();
        t_selftest();
        t_idle();
        t_midframe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule